// File: doc/BRIEF.md
# Shared-Source Interrupt Request Arbiter

This block lets several sub-sources (three by default, such as a group of timers) share one request line into an interrupt controller, while each sub-source keeps its own handler vector. Every sub-source event is captured in a per-source pending flag. One combined request is raised toward the controller, and a single in-service flag covers the whole group.

When the controller acknowledges the combined request, the block picks the pending sub-source with the lowest index, which has the highest priority. In the same cycle it presents that sub-source's vector and clears only that sub-source's pending flag. It also sets the in-service flag. The handler ends the service with an end-of-interrupt pulse. Until then every pending sub-source stays hidden from the controller, including one that outranks the source being served.

Top module: `sirq_arbiter`

## Requirements
- R1: While rst_ni is low and after its release, status_o, req_o, in_svc_o and vec_valid_o are all zero.
- R2: A high bit on evt_i[k] at a clock edge sets status_o[k] from that edge on. req_o is high whenever status_o is nonzero and in_svc_o is low.
- R3: In a cycle where ack_i is high and req_o is high, vec_valid_o is high and vec_o equals VEC_BASE (default 8'h20) plus the lowest index k with status_o[k] set. Index 0 has the highest priority.
- R4: An accepted acknowledge clears only the selected status bit at the next edge. Every other pending bit stays set.
- R5: An accepted acknowledge sets in_svc_o at the next edge. req_o then stays low while in_svc_o is high.
- R6: While in_svc_o is high, new events are still latched into status_o. req_o stays low even when the new event comes from a higher-priority sub-source.
- R7: A high eoi_i at an edge clears in_svc_o. req_o then reflects status_o again, so it rises if any bit is still pending.
- R8: ack_i while req_o is low is ignored. vec_valid_o stays low, and status_o and in_svc_o keep their values apart from the effect of events and end-of-interrupt.
- R9: If an event on sub-source k arrives in the same cycle that an acknowledge selects k, status_o[k] stays set.
- R10: eoi_i while in_svc_o is low has no effect: status_o and req_o are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Per-sub-source event pulses |
| ack_i | input | 1 | Acknowledge of the shared request |
| eoi_i | input | 1 | End of interrupt; clears in-service |
| req_o | output | 1 | Shared request toward the controller |
| in_svc_o | output | 1 | Shared in-service flag |
| vec_valid_o | output | 1 | High in an accepted acknowledge cycle |
| vec_o | output | VEC_W | Vector of the selected sub-source |
| status_o | output | N_SRC | Per-sub-source pending flags |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an acknowledge clearing sub-source k's flag while a new event on k sets it again. The bench drives the event and the acknowledge in one cycle, then checks that the vector names k, that in-service rises and that the flag is still set afterwards. The second pair is an end-of-interrupt arriving together with a fresh event. The bench checks that the event is latched and that the controller sees the request again only because in-service has dropped.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned DEF_N_SRC    = 3;
  localparam int unsigned DEF_VEC_W    = 8;
  localparam int unsigned DEF_VEC_BASE = 32'h20;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sirq_status_bank.sv
module sirq_status_bank #(
  parameter int unsigned N_SRC = sirq_pkg::DEF_N_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    // event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_q[g] <= 1'b0;
      else if (evt_i[g]) status_q[g] <= 1'b1;
      else if (clr_i[g]) status_q[g] <= 1'b0;
    end

    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> status_q[g]);
    assert_evt_beats_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[g] && clr_i[g]) |=> status_q[g]);
    assert_clr_only_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[g] && !clr_i[g]) |=> $stable(status_q[g]));
  end

  assign status_o = status_q;
endmodule

// File: rtl/sirq_prio_sel.sv
module sirq_prio_sel #(
  parameter int unsigned N_SRC = sirq_pkg::DEF_N_SRC,
  localparam int unsigned IDX_W = sirq_pkg::idx_width(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic [N_SRC-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N_SRC:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign gnt_o[g]  = pend_i[g] & ~seen[g];
    assign seen[g+1] = seen[g] | pend_i[g];
  end

  assign any_o = seen[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (gnt_o[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/sirq_service_ctl.sv
module sirq_service_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic eoi_i,
  output logic in_svc_o
);
  logic in_svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     in_svc_q <= 1'b0;
    else if (take_i) in_svc_q <= 1'b1;
    else if (eoi_i)  in_svc_q <= 1'b0;
  end

  assign in_svc_o = in_svc_q;

  assert_take_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> in_svc_q);
  assert_eoi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !take_i) |=> !in_svc_q);
  assert_take_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !in_svc_q);
endmodule

// File: rtl/sirq_arbiter.sv
module sirq_arbiter #(
  parameter int unsigned N_SRC    = sirq_pkg::DEF_N_SRC,
  parameter int unsigned VEC_W    = sirq_pkg::DEF_VEC_W,
  parameter int unsigned VEC_BASE = sirq_pkg::DEF_VEC_BASE,
  localparam int unsigned IDX_W   = sirq_pkg::idx_width(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             req_o,
  output logic             in_svc_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] gnt;
  logic [N_SRC-1:0] clr;
  logic [IDX_W-1:0] sel_idx;
  logic             any_pend;
  logic             in_svc;
  logic             take;

  sirq_status_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (clr),
    .status_o(status)
  );

  sirq_prio_sel #(.N_SRC(N_SRC)) u_sel (
    .pend_i(status),
    .gnt_o (gnt),
    .idx_o (sel_idx),
    .any_o (any_pend)
  );

  sirq_service_ctl u_svc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .eoi_i   (eoi_i),
    .in_svc_o(in_svc)
  );

  // shared request hidden for the whole group while in service
  assign req_o       = any_pend & ~in_svc;
  assign take        = ack_i & req_o;
  assign clr         = take ? gnt : '0;
  assign vec_valid_o = take;
  assign vec_o       = take ? VEC_W'(VEC_BASE + 32'(sel_idx)) : '0;
  assign in_svc_o    = in_svc;
  assign status_o    = status;

  assert_svc_masks_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc |-> !req_o);
  assert_sel_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> status[sel_idx]);
  assert_sel_highest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ((status & (gnt - 1'b1)) == '0));
  assert_idle_ack_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o) |=> status == ($past(status) | $past(evt_i)));
  assert_idle_eoi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !in_svc && !ack_i) |=> !in_svc);
endmodule

// File: tb/tb_sirq_arbiter.sv
`timescale 1ns/1ps
module tb_sirq_arbiter;
  localparam int unsigned N = 3;
  localparam int unsigned VB = 32'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       req, in_svc, vec_valid;
  logic [7:0] vec;
  logic [N-1:0] status;

  int nchk = 0, nfail = 0;
  logic       cv_valid;
  logic [7:0] cv_vec;

  always #4 clk = ~clk;

  sirq_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ack_i(ack), .eoi_i(eoi),
    .req_o(req), .in_svc_o(in_svc), .vec_valid_o(vec_valid), .vec_o(vec),
    .status_o(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle; capture combinational outputs before the edge
  task automatic step(input logic [N-1:0] e, input logic a, input logic d);
    @(negedge clk);
    evt = e; ack = a; eoi = d;
    #1;
    cv_valid = vec_valid;
    cv_vec   = vec;
    @(posedge clk);
    #1;
    evt = '0; ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", 32'(status), 0);
    chk("R1 req", 32'(req), 0);
    chk("R1 in_svc", 32'(in_svc), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
  endtask

  task automatic t_set_req;
    step(3'b100, 0, 0);
    chk("R2 status", 32'(status), 32'b100);
    chk("R2 req", 32'(req), 1);
    step(0, 1, 0);
    chk("R3 single vec", 32'(cv_vec), VB + 2);
    step(0, 0, 1);
  endtask

  task automatic t_priority;
    step(3'b011, 0, 0);
    chk("R2 status merge", 32'(status), 32'b011);
    step(3'b100, 1, 0);
    chk("R3 valid", 32'(cv_valid), 1);
    chk("R3 vec src0", 32'(cv_vec), VB + 0);
    chk("R4 status", 32'(status), 32'b110);
    chk("R5 in_svc", 32'(in_svc), 1);
    chk("R5 req low", 32'(req), 0);
    step(0, 0, 1);
    chk("R7 in_svc clr", 32'(in_svc), 0);
    chk("R7 req back", 32'(req), 1);
    step(0, 1, 0);
    chk("R3 vec src1", 32'(cv_vec), VB + 1);
    chk("R4 status2", 32'(status), 32'b100);
    step(0, 0, 1);
    step(0, 1, 0);
    chk("R3 vec src2", 32'(cv_vec), VB + 2);
    chk("R4 empty", 32'(status), 0);
    step(0, 0, 1);
    chk("R7 no req", 32'(req), 0);
  endtask

  task automatic t_block_higher;
    step(3'b100, 0, 0);
    step(0, 1, 0);
    chk("R3 vec low prio", 32'(cv_vec), VB + 2);
    step(3'b001, 0, 0);
    chk("R6 latched", 32'(status), 32'b001);
    chk("R6 req masked", 32'(req), 0);
    step(0, 1, 0);
    chk("R8 no valid", 32'(cv_valid), 0);
    chk("R8 status kept", 32'(status), 32'b001);
    chk("R8 in_svc kept", 32'(in_svc), 1);
    step(0, 0, 1);
    chk("R7 req after eoi", 32'(req), 1);
    step(0, 1, 0);
    chk("R6 vec after eoi", 32'(cv_vec), VB + 0);
    step(0, 0, 1);
  endtask

  task automatic t_ack_idle;
    step(0, 1, 0);
    chk("R8 idle valid", 32'(cv_valid), 0);
    chk("R8 idle in_svc", 32'(in_svc), 0);
    chk("R8 idle status", 32'(status), 0);
  endtask

  task automatic t_same_cycle;
    step(3'b001, 0, 0);
    step(3'b001, 1, 0);
    chk("R9 vec", 32'(cv_vec), VB + 0);
    chk("R9 bit kept", 32'(status), 32'b001);
    chk("R9 in_svc", 32'(in_svc), 1);
    step(3'b010, 0, 1);
    chk("R7 eoi+evt status", 32'(status), 32'b011);
    chk("R7 eoi+evt req", 32'(req), 1);
    step(0, 1, 0);
    step(0, 0, 1);
    step(0, 1, 0);
    step(0, 0, 1);
    chk("R9 drained", 32'(status), 0);
  endtask

  task automatic t_eoi_idle;
    step(3'b010, 0, 1);
    chk("R10 status", 32'(status), 32'b010);
    chk("R10 in_svc", 32'(in_svc), 0);
    step(0, 0, 1);
    chk("R10 req kept", 32'(req), 1);
    chk("R10 status kept", 32'(status), 32'b010);
    step(0, 1, 0);
    step(0, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_set_req();
    t_priority();
    t_block_higher();
    t_ack_idle();
    t_same_cycle();
    t_eoi_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule